// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block produces a clock whose frequency is the input frequency multiplied by 2/(2v+3). Here v is an unsigned divisor field read from a 32-bit control word, so the available ratios are 1.5, 2.5, 3.5 and upward. Each output period lasts an odd number of input half-periods. For that reason the block counts full input cycles on the rising edge and also acts on the falling edge. It combines a rising-edge toggle and a falling-edge toggle into the output.

The field sits at a parameterised bit position inside the control word, and every other bit of the word is ignored. A changed field value is adopted only at the start of an output period, so the output never shows a shortened high or low phase. An active-low asynchronous reset forces the output low and clears the internal state.

Top module: `halfstep_clkdiv`

## Requirements
- R1: The divisor is v = ctrl_word[FIELD_LSB +: W] (defaults FIELD_LSB=4, W=4). No other bit of ctrl_word affects the output.
- R2: In steady state, every output period lasts exactly 2v+3 input half-periods.
- R3: In steady state, each output period is high for v+1 input half-periods and low for v+2.
- R4: The ratio spans 3 half-periods at v=0 (divide by 1.5) up to 2^(W+1)+1 half-periods at v all-ones (33 for W=4).
- R5: While a divisor change takes effect, each output period is either a complete old-ratio period or a complete new-ratio period, with the matching high time. No runt pulse occurs.
- R6: After a field change, the period that ends at the third output rising edge already runs at the new ratio.
- R7: While rst_n is low, clk_out is low. After release, clk_out first rises at the first rising edge of clk_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word that carries the divisor field |
| clk_out | output | 1 | Divided clock |

## Verification
The bench sweeps every field value from 0 to 15 and times each output period and high phase in input half-periods. Each value in the sweep holds for four periods. This separates an off-by-one in the terminal count from an error in choosing which input edge carries each output edge. One run sets every bit outside the field to ones and zeros, which shows whether the field is extracted from the right position. Large jumps between the two extreme ratios, applied at varied phases, show whether a change can cut a period short or mix two ratios. A mid-run reset shows whether the first output edge after release comes at the right time.

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv #(
  parameter int W         = 4,
  parameter int FIELD_LSB = 4
) (
  input  logic        clk_in,
  input  logic        rst_n,
  input  logic [31:0] ctrl_word,
  output logic        clk_out
);
  localparam int CW = W + 2;

  logic [W-1:0]  act_v;
  logic [CW-1:0] cnt, nxt, last, v_ext, p_mid, n_mid;
  logic          tog_p, tog_n;
  logic          unused_ctrl;

  assign unused_ctrl = ^ctrl_word;
  assign v_ext = CW'(act_v);
  assign last  = (v_ext << 1) + CW'(2);
  assign nxt   = (cnt == last) ? '0 : cnt + CW'(1);
  assign p_mid = act_v[0] ? ((v_ext + CW'(1)) >> 1) : ((v_ext * CW'(3) + CW'(4)) >> 1);
  assign n_mid = act_v[0] ? ((v_ext * CW'(3) + CW'(3)) >> 1) : (v_ext >> 1);

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      act_v <= '0;
      cnt   <= CW'(2);
      tog_p <= 1'b0;
    end else begin
      cnt <= nxt;
      if (nxt == '0) act_v <= ctrl_word[FIELD_LSB +: W];
      if (nxt == '0 || nxt == p_mid) tog_p <= ~tog_p;
    end

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) tog_n <= 1'b0;
    else if (cnt == v_ext + CW'(1) || cnt == n_mid) tog_n <= ~tog_n;

  assign clk_out = tog_p ^ tog_n;

  a_r2_count_in_range: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt <= last);
  a_r5_load_at_wrap: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(act_v) |-> cnt == '0);
  a_r3_high_after_start: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt == '0 && act_v != '0) |-> clk_out);
  a_r3_low_before_wrap: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt == last |-> !clk_out);
endmodule

// File: tb/sim_halfstep_clkdiv.sv
module sim_halfstep_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int W = 4;
  localparam int LSB = 4;

  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic clk_out;

  halfstep_clkdiv #(.W(W), .FIELD_LSB(LSB)) u0 (
    .clk_in(clk_in), .rst_n(rst_n), .ctrl_word(ctrl_word), .clk_out(clk_out)
  );

  always #(HALF) clk_in = ~clk_in;

  typedef struct { int per; int hi; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;
  int pa = 3, ha = 1, pb = 3, hb = 1, cur_per = 3, cur_hi = 1;
  int per, hi, last_per;
  bit armed = 0, finished = 0;
  time t_rise, t_fall, t_rel;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk_out);
    if (armed) begin
      per = int'(($time - t_rise) / HALF);
      hi  = int'((t_fall - t_rise) / HALF);
      last_per = per;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(per == e.per, e.tag, "period", per, e.per);
        chk(hi == e.hi, "R3", "high time", hi, e.hi);
      end else
        chk((per == pa && hi == ha) || (per == pb && hi == hb), "R5", "transition period", per, pb);
    end
    t_rise = $time;
    armed = 1;
  end

  initial forever begin
    @(negedge clk_out);
    t_fall = $time;
  end

  task automatic set_v(input int v, input logic [31:0] noise, input int delay, input string tag);
    repeat (delay) @(negedge clk_in);
    @(negedge clk_in);
    pa = cur_per; ha = cur_hi; pb = 2 * v + 3; hb = v + 1;
    ctrl_word = (noise & ~(32'hF << LSB)) | (32'(v) << LSB);
    repeat (3) @(posedge clk_out);
    #1;
    chk(last_per == pb, "R6", "period at third rise", last_per, pb);
    for (int k = 0; k < 4; k++) q.push_back('{2 * v + 3, v + 1, tag});
    while (q.size() != 0) @(posedge clk_in);
    cur_per = pb; cur_hi = hb;
  endtask

  task automatic do_reset(input int hold);
    @(negedge clk_in);
    rst_n = 1'b0;
    armed = 0;
    #1;
    chk(clk_out == 1'b0, "R7", "low at reset entry", int'(clk_out), 0);
    for (int k = 0; k < hold; k++) begin
      @(posedge clk_in); #1;
      chk(clk_out == 1'b0, "R7", "low during reset", int'(clk_out), 0);
    end
    pa = cur_per; ha = cur_hi; pb = cur_per; hb = cur_hi;
    @(negedge clk_in);
    t_rel = $time;
    rst_n = 1'b1;
    @(posedge clk_out);
    chk(($time - t_rel) == HALF, "R7", "first rise delay", int'($time - t_rel), HALF);
  endtask

  initial begin
    do_reset(3);
    for (int v = 0; v < 16; v++)
      set_v(v, 32'h0, v % 3, (v == 0 || v == 15) ? "R4" : "R2");
    set_v(5, 32'hA5A5_A5FA, 1, "R1");
    set_v(9, 32'hFFFF_FF0F, 2, "R1");
    set_v(15, 32'h0, 7, "R5");
    set_v(0, 32'h0, 11, "R5");
    set_v(15, 32'h0, 2, "R5");
    set_v(1, 32'h0, 20, "R5");
    set_v(15, 32'h0, 0, "R2");
    do_reset(2);
    set_v(9, 32'h0, 4, "R2");
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule